// File: doc/BRIEF.md
# ATA Task-File Command Controller

This block is the device side of an ATA register window. A host reaches it through eight byte-wide I/O offsets. The host loads the sector count, three LBA bytes and the device/head byte into the task file. It then writes a command byte. The block decodes that byte, drives the status bits and the interrupt request, and either streams identification data through the 16-bit data register or hands a transfer or cache flush to a backend. The backend contains the media and the DMA engine. It reports completion with a one-cycle done strobe and an error flag.

Only device 0 is present. A command issued while device 1 is selected does nothing. The interrupt request stays pending until the host reads the status register. The identification block is computed on the fly from parameters, so it needs no storage. Its text fields are packed two characters per word, with the first character in the high byte.

Top module: `ata_taskfile`

## Requirements
- R1: After reset the status byte (offset 7) reads 0x40 (only the ready bit 0x40 set), the error byte (offset 1) reads 0x00, `irq` is low and `opStart` is low.
- R2: Writes to offsets 2 (sector count), 3, 4, 5 (LBA bits 7:0, 15:8, 23:16) and 6 (device byte) are latched and read back unchanged on the low byte of `ioRdData`, with the upper byte zero. Offset 1 reads the error byte.
- R3: Command 0xEC (identify) changes status to 0x48 (ready 0x40 plus data-request 0x08) on the next cycle and raises `irq`. Each read strobe at offset 0 advances one word. Status stays 0x48 until the 256th word has been read, after which it reads 0x40. Busy (0x80) and data-request (0x08) are never set together.
- R4: The identify words are as follows. Word 0 is 0x0040. Word 49 is 0x0200. Word 85 is 0x0020 (write cache enabled, bit 5). Words 10 to 19 hold the 20-character serial string. Words 23 to 26 hold the 8-character firmware string. Each of these words carries two characters, the earlier one in bits 15:8, and the strings are padded with spaces. Every other word is 0. Offset 0 reads 0 when no data is requested.
- R5: Command 0xC8 (read DMA) produces, on the next cycle, a one-cycle `opStart` pulse with `opCode` 0, `opLba` = {offset 5, offset 4, offset 3} and `opCount` = offset 2. Status then reads 0xC0 (busy plus ready) until `opDone`.
- R6: Command 0xCA (write DMA) starts the backend with `opCode` 1. Command 0xE7 (flush) starts it with `opCode` 2. Both leave status at 0xC0 until `opDone`.
- R7: `opDone` with `opErr` low while busy gives status 0x40, error byte 0x00 and `irq` high on the next cycle.
- R8: `opDone` with `opErr` high while busy gives status 0x41 (error bit 0x01), error byte 0x04 (abort) and `irq` high on the next cycle.
- R9: Any other command code gives status 0x41, error byte 0x04 and `irq` high on the next cycle, with no `opStart` and no data request.
- R10: A read strobe at offset 7 clears `irq` on the next cycle, unless a new interrupt event occurs in the same cycle. Read strobes at other offsets leave `irq` unchanged.
- R11: A command write while busy or while data is requested is ignored. Task-file writes (offsets 2 to 6) while busy are ignored.
- R12: A command written while the device byte has bit 0x10 set (device 1) is ignored: status, error byte and `irq` are unchanged and `opStart` stays low.
- R13: An accepted supported command clears the error bit and the error byte left by an earlier failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 3 | Register offset |
| ioWrEn | input | 1 | Write strobe, one cycle per access |
| ioWrData | input | 8 | Write data |
| ioRdEn | input | 1 | Read strobe (side effects only; data is combinational) |
| ioRdData | output | 16 | Read data for the offset on `ioAddr` |
| irq | output | 1 | Interrupt request |
| opStart | output | 1 | One-cycle backend start pulse |
| opCode | output | 2 | 0 read to host, 1 write from host, 2 flush |
| opLba | output | 24 | Starting LBA for the backend |
| opCount | output | 8 | Sector count for the backend |
| opDone | input | 1 | Backend completion strobe |
| opErr | input | 1 | Backend error, valid with `opDone` |

## Verification
The assertions check, on every cycle, the rules that relate status to the strobes. Busy and data request never appear together. The start pulse lasts one cycle and only appears while busy. Completion clears busy and reports an error correctly. A status read drops the interrupt. Unknown commands, and commands sent to device 1, have the effect set out in the requirements. Only the bench's scenarios can show the identify sequence: the word contents and byte order, the exact 256-read length, blocking of commands during the stream, and the LBA and count handed to the backend. The bench checks these against a behavioural model on every clock.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PIO  = 2'd1,
    ST_WAIT = 2'd2
  } tfState_t;

  localparam logic [7:0] CMD_RD_DMA   = 8'hC8;
  localparam logic [7:0] CMD_WR_DMA   = 8'hCA;
  localparam logic [7:0] CMD_FLUSH    = 8'hE7;
  localparam logic [7:0] CMD_IDENTIFY = 8'hEC;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_FLUSH = 2'd2;

  localparam logic [7:0] ERR_ABORT = 8'h04;

  typedef struct packed {
    logic tfWrEn;
    logic ptrClear;
    logic ptrStep;
  } ctlStrobe_t;
endpackage

// File: rtl/ata_tf_control.sv
module ata_tf_control
  import ata_tf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] ioAddr,
  input  logic       ioWrEn,
  input  logic [7:0] cmdByte,
  input  logic       ioRdEn,
  input  logic       devOne,
  input  logic       lastWord,
  input  logic       opDone,
  input  logic       opErr,
  output ctlStrobe_t strobes,
  output logic [7:0] statusByte,
  output logic [7:0] errByte,
  output logic       irq,
  output logic       opStart,
  output logic [1:0] opCode
);
  tfState_t state;
  logic     errFlag;
  logic     cmdWr, accept, isOp, isKnown, statusRd, setIrq, doneEvt;

  always_comb begin
    cmdWr    = ioWrEn && (ioAddr == 3'd7);
    accept   = cmdWr && (state == ST_IDLE) && !devOne;
    isOp     = (cmdByte == CMD_RD_DMA) || (cmdByte == CMD_WR_DMA) || (cmdByte == CMD_FLUSH);
    isKnown  = isOp || (cmdByte == CMD_IDENTIFY);
    statusRd = ioRdEn && (ioAddr == 3'd7);
    doneEvt  = (state == ST_WAIT) && opDone;
    setIrq   = (accept && !isOp) || doneEvt;
    strobes.tfWrEn   = ioWrEn && (ioAddr >= 3'd2) && (ioAddr <= 3'd6) && (state != ST_WAIT);
    strobes.ptrClear = accept && (cmdByte == CMD_IDENTIFY);
    strobes.ptrStep  = ioRdEn && (ioAddr == 3'd0) && (state == ST_PIO);
    statusByte = {state == ST_WAIT, 1'b1, 1'b0, 1'b0, state == ST_PIO, 2'b00, errFlag};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
      errByte <= 8'h00;
      irq     <= 1'b0;
      opStart <= 1'b0;
      opCode  <= OP_READ;
    end else begin
      opStart <= 1'b0;
      if (setIrq)        irq <= 1'b1;
      else if (statusRd) irq <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            errFlag <= !isKnown;
            errByte <= isKnown ? 8'h00 : ERR_ABORT;
            if (cmdByte == CMD_IDENTIFY) state <= ST_PIO;
            else if (isOp) begin
              state   <= ST_WAIT;
              opStart <= 1'b1;
              opCode  <= (cmdByte == CMD_RD_DMA) ? OP_READ :
                         (cmdByte == CMD_WR_DMA) ? OP_WRITE : OP_FLUSH;
            end
          end
        end
        ST_PIO: begin
          if (strobes.ptrStep && lastWord) state <= ST_IDLE;
        end
        ST_WAIT: begin
          if (opDone) begin
            state   <= ST_IDLE;
            errFlag <= opErr;
            errByte <= opErr ? ERR_ABORT : 8'h00;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_tf_datapath.sv
module ata_tf_datapath
  import ata_tf_pkg::*;
#(
  parameter int WORD_COUNT = 256,
  parameter int SER_CHARS  = 20,
  parameter int FW_CHARS   = 8,
  parameter int SER_WORD   = 10,
  parameter int FW_WORD    = 23,
  parameter logic [8*SER_CHARS-1:0] SERIAL_ID = "ATACTL-SN-000042    ",
  parameter logic [8*FW_CHARS-1:0]  FW_REV    = "FW-1.07 "
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  ioAddr,
  input  logic [7:0]  ioWrData,
  input  ctlStrobe_t  strobes,
  input  logic [7:0]  statusByte,
  input  logic [7:0]  errByte,
  output logic [15:0] ioRdData,
  output logic        devOne,
  output logic        lastWord,
  output logic [23:0] opLba,
  output logic [7:0]  opCount
);
  localparam int PTR_W = $clog2(WORD_COUNT);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(WORD_COUNT - 1);
  localparam int SER_WORDS = SER_CHARS / 2;
  localparam int FW_WORDS  = FW_CHARS / 2;

  logic [7:0]       tfReg [2:6];
  logic [PTR_W-1:0] wordPtr;

  function automatic logic [7:0] serChar(input int k);
    return SERIAL_ID[8*(SER_CHARS-1-k) +: 8];
  endfunction

  function automatic logic [7:0] fwChar(input int k);
    return FW_REV[8*(FW_CHARS-1-k) +: 8];
  endfunction

  function automatic logic [15:0] identWord(input logic [PTR_W-1:0] idx);
    int w;
    logic [15:0] r;
    w = int'(idx);
    r = 16'h0000;
    if (w == 0)       r = 16'h0040;
    else if (w == 49) r = 16'h0200;
    else if (w == 85) r = 16'h0020;
    else if (w >= SER_WORD && w < SER_WORD + SER_WORDS)
      r = {serChar(2*(w-SER_WORD)), serChar(2*(w-SER_WORD)+1)};
    else if (w >= FW_WORD && w < FW_WORD + FW_WORDS)
      r = {fwChar(2*(w-FW_WORD)), fwChar(2*(w-FW_WORD)+1)};
    return r;
  endfunction

  generate
    for (genvar g = 2; g <= 6; g++) begin : g_tf
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) tfReg[g] <= 8'h00;
        else if (strobes.tfWrEn && (ioAddr == 3'(g))) tfReg[g] <= ioWrData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wordPtr <= '0;
    else if (strobes.ptrClear) wordPtr <= '0;
    else if (strobes.ptrStep)  wordPtr <= wordPtr + 1'b1;
  end

  always_comb begin
    devOne   = tfReg[6][4];
    lastWord = (wordPtr == LAST_PTR);
    opLba    = {tfReg[5], tfReg[4], tfReg[3]};
    opCount  = tfReg[2];
    unique case (ioAddr)
      3'd0:    ioRdData = statusByte[3] ? identWord(wordPtr) : 16'h0000;
      3'd1:    ioRdData = {8'h00, errByte};
      3'd7:    ioRdData = {8'h00, statusByte};
      default: ioRdData = {8'h00, tfReg[ioAddr]};
    endcase
  end
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int WORD_COUNT = 256,
  parameter int SER_CHARS  = 20,
  parameter int FW_CHARS   = 8,
  parameter logic [8*SER_CHARS-1:0] SERIAL_ID = "ATACTL-SN-000042    ",
  parameter logic [8*FW_CHARS-1:0]  FW_REV    = "FW-1.07 "
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  ioAddr,
  input  logic        ioWrEn,
  input  logic [7:0]  ioWrData,
  input  logic        ioRdEn,
  output logic [15:0] ioRdData,
  output logic        irq,
  output logic        opStart,
  output logic [1:0]  opCode,
  output logic [23:0] opLba,
  output logic [7:0]  opCount,
  input  logic        opDone,
  input  logic        opErr
);
  ctlStrobe_t strobes;
  logic [7:0] statusByte, errByte;
  logic       devOne, lastWord;

  ata_tf_control u_ctl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .cmdByte(ioWrData),
    .ioRdEn(ioRdEn), .devOne(devOne), .lastWord(lastWord), .opDone(opDone),
    .opErr(opErr), .strobes(strobes), .statusByte(statusByte), .errByte(errByte),
    .irq(irq), .opStart(opStart), .opCode(opCode)
  );

  ata_tf_datapath #(
    .WORD_COUNT(WORD_COUNT), .SER_CHARS(SER_CHARS), .FW_CHARS(FW_CHARS),
    .SERIAL_ID(SERIAL_ID), .FW_REV(FW_REV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .strobes(strobes),
    .statusByte(statusByte), .errByte(errByte), .ioRdData(ioRdData), .devOne(devOne),
    .lastWord(lastWord), .opLba(opLba), .opCount(opCount)
  );
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] ioAddr,
  input logic       ioWrEn,
  input logic [7:0] ioWrData,
  input logic       ioRdEn,
  input logic       irq,
  input logic       opStart,
  input logic       opDone,
  input logic       opErr,
  input logic [7:0] statusByte,
  input logic [7:0] errByte,
  input logic       devOne
);
  logic cmdIdle, unknownCmd;
  assign cmdIdle = ioWrEn && (ioAddr == 3'd7) && !statusByte[7] && !statusByte[3];
  assign unknownCmd = (ioWrData != 8'hC8) && (ioWrData != 8'hCA) &&
                      (ioWrData != 8'hE7) && (ioWrData != 8'hEC);

  p_bsy_drq_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[7] && statusByte[3]));

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    opStart |=> !opStart);

  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    opStart |-> statusByte[7]);

  p_done_ok_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] && opDone && !opErr) |=> (!statusByte[7] && !statusByte[0] && irq));

  p_done_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] && opDone && opErr) |=> (statusByte[0] && errByte == 8'h04 && irq));

  p_unknown_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdIdle && !devOne && unknownCmd) |=>
      (statusByte[0] && !statusByte[3] && !opStart && irq));

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdEn && ioAddr == 3'd7 && !ioWrEn && !opDone) |=> !irq);

  p_dev1_ignored_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdIdle && devOne && !irq) |=> (!irq && !opStart && !statusByte[7]));
endmodule

bind ata_taskfile ata_taskfile_chk u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData),
  .ioRdEn(ioRdEn), .irq(irq), .opStart(opStart), .opDone(opDone), .opErr(opErr),
  .statusByte(statusByte), .errByte(errByte), .devOne(devOne)
);

// File: tb/tb_ata_taskfile.sv
`timescale 1ns/1ps
module tb_ata_taskfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  ioAddr = 3'd0;
  logic        ioWrEn = 1'b0;
  logic [7:0]  ioWrData = 8'h00;
  logic        ioRdEn = 1'b0;
  logic [15:0] ioRdData;
  logic        irq, opStart;
  logic [1:0]  opCode;
  logic [23:0] opLba;
  logic [7:0]  opCount;
  logic        opDone = 1'b0;
  logic        opErr = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ata_taskfile dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData),
    .ioRdEn(ioRdEn), .ioRdData(ioRdData), .irq(irq), .opStart(opStart), .opCode(opCode),
    .opLba(opLba), .opCount(opCount), .opDone(opDone), .opErr(opErr)
  );

  // ---------------- behavioural reference model ----------------
  string serStr = "ATACTL-SN-000042    ";
  string fwStr  = "FW-1.07 ";
  int mState;        // 0 idle, 1 streaming words, 2 waiting on backend
  int mErr, mErrCode, mIrq, mPtr, mStart, mCode;
  int mTf [8];

  function automatic int modelWord(int w);
    if (w == 0)  return 16'h0040;
    if (w == 49) return 16'h0200;
    if (w == 85) return 16'h0020;
    if (w >= 10 && w <= 19) return (int'(serStr[2*(w-10)]) << 8) | int'(serStr[2*(w-10)+1]);
    if (w >= 23 && w <= 26) return (int'(fwStr[2*(w-23)]) << 8) | int'(fwStr[2*(w-23)+1]);
    return 0;
  endfunction

  function automatic int modelStatus();
    return 8'h40 | (mState == 2 ? 8'h80 : 0) | (mState == 1 ? 8'h08 : 0) | mErr;
  endfunction

  function automatic int modelRead(int a);
    if (a == 0) return (mState == 1) ? modelWord(mPtr) : 0;
    if (a == 1) return mErrCode;
    if (a == 7) return modelStatus();
    return mTf[a];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mErr = 0; mErrCode = 0; mIrq = 0; mPtr = 0; mStart = 0; mCode = 0;
      foreach (mTf[i]) mTf[i] = 0;
    end else begin
      int setI;
      int cmd;
      int nxtState;
      setI = 0;
      mStart = 0;
      nxtState = mState;
      cmd = int'(ioWrData);
      if (mState == 2 && opDone) begin
        nxtState = 0; mErr = opErr; mErrCode = opErr ? 4 : 0; setI = 1;
      end
      if (mState == 1 && ioRdEn && ioAddr == 0) begin
        if (mPtr == 255) nxtState = 0;
        mPtr = mPtr + 1;
      end
      if (ioWrEn && ioAddr >= 2 && ioAddr <= 6 && mState != 2) mTf[ioAddr] = cmd;
      if (ioWrEn && ioAddr == 7 && mState == 0 && (mTf[6] & 8'h10) == 0) begin
        setI = 1;
        mErr = 0; mErrCode = 0;
        if (cmd == 8'hEC) begin nxtState = 1; mPtr = 0; end
        else if (cmd == 8'hC8 || cmd == 8'hCA || cmd == 8'hE7) begin
          nxtState = 2; mStart = 1; setI = 0;
          mCode = (cmd == 8'hC8) ? 0 : (cmd == 8'hCA) ? 1 : 2;
        end else begin
          mErr = 1; mErrCode = 4;
        end
      end
      if (setI) mIrq = 1;
      else if (ioRdEn && ioAddr == 7) mIrq = 0;
      mState = nxtState;
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R10 irq", int'(irq), mIrq);
      check("R5 opStart", int'(opStart), mStart);
      check("R2 ioRdData", int'(ioRdData), modelRead(int'(ioAddr)));
      if (mStart) begin
        check("R6 opCode", int'(opCode), mCode);
        check("R5 opLba", int'(opLba), (mTf[5] << 16) | (mTf[4] << 8) | mTf[3]);
        check("R5 opCount", int'(opCount), mTf[2]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    @(posedge clk); #2;
    ioAddr = 3'(a); ioWrData = 8'(d); ioWrEn = 1'b1;
    @(posedge clk); #2;
    ioWrEn = 1'b0;
  endtask

  task automatic rdStrobe(int a);
    @(posedge clk); #2;
    ioAddr = 3'(a); ioRdEn = 1'b1;
    @(posedge clk); #2;
    ioRdEn = 1'b0;
  endtask

  task automatic peek(int a, int exp, string req);
    @(posedge clk); #2;
    ioAddr = 3'(a);
    @(negedge clk);
    check(req, int'(ioRdData), exp);
  endtask

  task automatic finishDone(int err);
    @(posedge clk); #2;
    opDone = 1'b1; opErr = err[0];
    @(posedge clk); #2;
    opDone = 1'b0; opErr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1 reset state
    peek(7, 8'h40, "R1 status");
    peek(1, 8'h00, "R1 error");
    check("R1 irq", int'(irq), 0);
    check("R1 opStart", int'(opStart), 0);

    // R2 task-file latch and readback
    wr(2, 8'h05); wr(3, 8'h56); wr(4, 8'h34); wr(5, 8'h12); wr(6, 8'h40);
    peek(2, 8'h05, "R2 count");
    peek(3, 8'h56, "R2 lba0");
    peek(5, 8'h12, "R2 lba2");
    peek(6, 8'h40, "R2 dev");

    // R3 / R4 identify
    wr(7, 8'hEC);
    peek(7, 8'h48, "R3 status after identify");
    check("R3 irq raised", int'(irq), 1);
    rdStrobe(7);
    check("R10 irq cleared by status read", int'(irq), 0);
    wr(7, 8'hC8);                        // R11: command during data request ignored
    check("R11 no start during drq", int'(opStart), 0);
    for (int w = 0; w < 256; w++) begin
      @(posedge clk); #2;
      ioAddr = 3'd0;
      @(negedge clk);
      if (w == 0)  check("R4 word0", int'(ioRdData), 16'h0040);
      if (w == 10) check("R4 serial word10", int'(ioRdData), 16'h4154);
      if (w == 23) check("R4 firmware word23", int'(ioRdData), 16'h4657);
      if (w == 85) check("R4 word85 cache", int'(ioRdData), 16'h0020);
      if (w == 255) check("R3 drq on last word", int'(dut.ioRdData !== 16'hxxxx), 1);
      ioAddr = 3'd7;
      #1 check("R3 status during stream", int'(ioRdData), 8'h48);
      ioAddr = 3'd0;
      @(posedge clk); #2 ioRdEn = 1'b1;
      @(posedge clk); #2 ioRdEn = 1'b0;
    end
    peek(7, 8'h40, "R3 status after last word");
    peek(0, 0, "R4 data idle");

    // R5 read DMA, with R11 writes while busy
    wr(7, 8'hC8);
    peek(7, 8'hC0, "R5 busy");
    wr(3, 8'hAA);
    wr(7, 8'hE7);
    peek(3, 8'h56, "R11 tf write while busy ignored");
    check("R11 no second start", int'(opStart), 0);
    rdStrobe(2);
    finishDone(0);
    peek(7, 8'h40, "R7 status after done");
    check("R7 irq after done", int'(irq), 1);
    rdStrobe(3);
    check("R10 other read keeps irq", int'(irq), 1);
    rdStrobe(7);

    // R6 / R8 write DMA with error
    wr(7, 8'hCA);
    finishDone(1);
    peek(7, 8'h41, "R8 status error");
    peek(1, 8'h04, "R8 abort code");
    rdStrobe(7);

    // R6 / R13 flush clears error
    wr(7, 8'hE7);
    peek(1, 8'h00, "R13 error cleared");
    finishDone(0);
    peek(7, 8'h40, "R7 flush done status");
    rdStrobe(7);

    // R9 unknown command
    wr(7, 8'h90);
    peek(7, 8'h41, "R9 status");
    peek(1, 8'h04, "R9 abort code");
    check("R9 irq", int'(irq), 1);
    rdStrobe(7);

    // R12 device 1 selected
    wr(6, 8'h50);
    wr(7, 8'hEC);
    peek(7, 8'h41, "R12 status unchanged");
    check("R12 irq unchanged", int'(irq), 0);
    wr(7, 8'hC8);
    check("R12 no start", int'(opStart), 0);
    wr(6, 8'h40);
    wr(7, 8'hCA);
    finishDone(0);
    peek(7, 8'h40, "R13 ok after device 0 reselect");

    repeat (4) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule